// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier with Early Termination

This block computes the low word of the product of two integers over several clock cycles. Each clock it examines a three-bit window of the multiplier. The window overlaps the previous one by one bit. The window is recoded into a signed digit between -2 and +2. The matching multiple of the multiplicand is added into an accumulator. The multiplicand then moves two places left and the multiplier two places right. Each clock therefore retires two multiplier bits.

The operation stops as soon as the multiplier bits still to be scanned carry no further information. That point is reached when those bits, together with the last bit already scanned, are all zeros or all ones. Small multipliers of either sign therefore finish in fewer cycles than large ones. The low word of a product is the same for signed and unsigned operands, so one datapath serves both. A request is a one-cycle start pulse with both operands. The block answers with a one-cycle done pulse, and the product stays registered until the next result.

Top module: `booth_mul`

## Requirements
- R1: At the done pulse, `product_o` equals the low WIDTH bits of `multiplicand_i * multiplier_i`, with the operands taken from the cycle in which start was accepted. The value is the same whether the operands are read as signed or as unsigned.
- R2: A start pulse seen while idle is accepted at that clock edge, and `busy_o` is high from the next cycle. `busy_o` stays high through every iteration and falls in the same cycle that `done_o` rises.
- R3: `done_o` is high for exactly one cycle per accepted operation. `product_o` changes only together with a done pulse and holds its value between pulses.
- R4: The number of iteration cycles is the smallest k >= 1 such that the multiplier, read as a WIDTH-bit two's complement value, lies in [-2^(2k-1), 2^(2k-1)). The number never exceeds WIDTH/2, which is 16 at the default width. `done_o` rises k cycles after the accepting edge.
- R5: A multiplier of zero finishes after a single iteration cycle.
- R6: A start pulse while `busy_o` is high is ignored. The running operation keeps its operands and its latency, and no second operation follows it.
- R7: After synchronous reset, `busy_o` and `done_o` are low and `product_o` is zero.
- R8: The window recoding, with the window read as bits (i+1, i, i-1), is: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request; taken only while idle |
| multiplicand_i | input | WIDTH | Multiplicand, sampled when start is accepted |
| multiplier_i | input | WIDTH | Multiplier, sampled when start is accepted |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | WIDTH | Low word of the product, held between pulses |

## Verification
The assertions assume that operands matter only in the cycle where start is accepted. They also assume that start may arrive at any time, including while busy, and they make no assumption about how start is spaced. The bench drives operands only together with start, except in the test that pulses start mid-operation. That test checks that the pulse changes nothing. A six-bit instance is swept over every operand pair, which covers every multiplier bit pattern and every early-out length at that width. The default-width instance is given the extreme multipliers (zero, one, minus one, the most negative value and values at each power-of-four boundary), plus random operands.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_P1   = 3'd1,
    DIG_P2   = 3'd2,
    DIG_M1   = 3'd3,
    DIG_M2   = 3'd4
  } booth_digit_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } booth_state_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0]   window_i,
  output booth_digit_e digit_o
);
  always_comb begin
    unique case (window_i)
      3'b001, 3'b010: digit_o = DIG_P1;
      3'b011:         digit_o = DIG_P2;
      3'b100:         digit_o = DIG_M2;
      3'b101, 3'b110: digit_o = DIG_M1;
      default:        digit_o = DIG_ZERO;
    endcase
  end
endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_digit_e     digit_i,
  output logic [WIDTH-1:0] pp_o
);
  logic [WIDTH-1:0] dbl;
  assign dbl = {mcand_i[WIDTH-2:0], 1'b0};

  always_comb begin
    unique case (digit_i)
      DIG_P1:  pp_o = mcand_i;
      DIG_P2:  pp_o = dbl;
      DIG_M1:  pp_o = ~mcand_i + WIDTH'(1);
      DIG_M2:  pp_o = ~dbl + WIDTH'(1);
      default: pp_o = '0;
    endcase
  end
endmodule

// File: rtl/booth_early_out.sv
module booth_early_out #(
  parameter int BITS = 33
) (
  input  logic [BITS-1:0] rest_i,
  output logic            uniform_o
);
  assign uniform_o = (&rest_i) | ~(|rest_i);
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int ITER = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic uniform_i,
  output logic accept_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(ITER + 1);

  booth_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_step;

  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign last_step = (cnt_q == CNT_W'(ITER - 1));
  assign finish_o  = (state_q == ST_RUN) && (uniform_i || last_step);
  assign busy_o    = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= finish_o;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i) state_q <= ST_RUN;
        end
        default: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (finish_o) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R4: never more iterations than multiplier digit positions
  assert_iter_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt_q < CNT_W'(ITER)));

  // R3: done never lasts two cycles
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2: busy ends exactly when done appears
  assert_busy_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R2: done and busy are never high together
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R6: a run is only left through finish, start cannot restart it
  assert_run_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !finish_o) |=> busy_o);
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIDTH-1:0] multiplicand_i,
  input  logic [WIDTH-1:0] multiplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] product_o
);
  localparam int ITER = WIDTH / 2;
  localparam int QW   = WIDTH + 1;

  logic [WIDTH-1:0] acc_q, mcand_q, pp, acc_next, mcand_next;
  logic [QW-1:0]    mq_q, mq_next;
  booth_digit_e     digit;
  logic             uniform, accept, finish;

  booth_recoder u_rec (
    .window_i (mq_q[2:0]),
    .digit_o  (digit)
  );

  booth_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .mcand_i (mcand_q),
    .digit_i (digit),
    .pp_o    (pp)
  );

  assign acc_next   = acc_q + pp;
  assign mcand_next = {mcand_q[WIDTH-3:0], 2'b00};
  assign mq_next    = {{2{mq_q[QW-1]}}, mq_q[QW-1:2]};

  booth_early_out #(.BITS(QW)) u_eo (
    .rest_i    (mq_next),
    .uniform_o (uniform)
  );

  booth_ctrl #(.ITER(ITER)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .uniform_i (uniform),
    .accept_o  (accept),
    .finish_o  (finish),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      mcand_q   <= '0;
      mq_q      <= '0;
      product_o <= '0;
    end else begin
      if (accept) begin
        acc_q   <= '0;
        mcand_q <= multiplicand_i;
        mq_q    <= {multiplier_i, 1'b0};
      end else if (busy_o) begin
        acc_q   <= acc_next;
        mcand_q <= mcand_next;
        mq_q    <= mq_next;
      end
      if (finish) product_o <= acc_next;
    end
  end

  // R5: a zero multiplier completes in its first iteration
  assert_zero_fast_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && (multiplier_i == '0)) |=> finish);

  // R8: uniform windows add nothing to the accumulator
  assert_zero_window_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && ((mq_q[2:0] == 3'b000) || (mq_q[2:0] == 3'b111))) |-> (acc_next == acc_q));

  // R8: window 011 adds twice the shifted multiplicand
  assert_plus_two_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (mq_q[2:0] == 3'b011)) |-> (acc_next == acc_q + {mcand_q[WIDTH-2:0], 1'b0}));

  // R8: window 100 subtracts twice the shifted multiplicand
  assert_minus_two_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (mq_q[2:0] == 3'b100)) |-> (acc_next + {mcand_q[WIDTH-2:0], 1'b0} == acc_q));

  // R3: the product only moves together with a done pulse
  assert_product_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(product_o));

  // R2: busy follows an accepted start
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_o);
endmodule

// File: tb/tb_booth_mul.sv
module tb_booth_mul;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          start, busy, done;
  logic [W-1:0]  a, b, prod;
  logic          s_start, s_busy, s_done;
  logic [SW-1:0] s_a, s_b, s_prod;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  booth_mul #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .start_i(start), .multiplicand_i(a), .multiplier_i(b),
    .busy_o(busy), .done_o(done), .product_o(prod)
  );

  booth_mul #(.WIDTH(SW)) dut_small (
    .clk(clk), .rst(rst), .start_i(s_start), .multiplicand_i(s_a), .multiplier_i(s_b),
    .busy_o(s_busy), .done_o(s_done), .product_o(s_prod)
  );

  function automatic int exp_lat(longint v, int w);
    for (int k = 1; k <= w / 2; k++) begin
      longint lim = longint'(1) << (2 * k - 1);
      if (v >= -lim && v < lim) return k;
    end
    return w / 2;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run32(logic [W-1:0] x, logic [W-1:0] y);
    int n = 0;
    logic [W-1:0] e;
    int el;
    e  = W'(longint'(x) * longint'(y));
    el = exp_lat(longint'($signed(y)), W);
    @(negedge clk); start = 1'b1; a = x; b = y;
    @(negedge clk); start = 1'b0; a = '0; b = '0;
    chk(busy && !done, "R2 busy after start", longint'(busy), 1);
    while (n < 40) begin
      @(negedge clk); n++;
      if (done) break;
      chk(busy, "R2 busy during run", longint'(busy), 1);
    end
    chk(!busy, "R2 busy low at done", longint'(busy), 0);
    chk(prod == e, "R1 product", longint'(prod), longint'(e));
    chk(n == el, (y == 0) ? "R5 zero latency" : "R4 latency", n, el);
  endtask

  task automatic run6(logic [SW-1:0] x, logic [SW-1:0] y);
    int n = 0;
    logic [SW-1:0] e;
    int el;
    e  = SW'(longint'(x) * longint'(y));
    el = exp_lat(longint'($signed(y)), SW);
    @(negedge clk); s_start = 1'b1; s_a = x; s_b = y;
    @(negedge clk); s_start = 1'b0;
    while (n < 10) begin
      @(negedge clk); n++;
      if (s_done) break;
    end
    chk(s_prod == e, "R1 small product", longint'(s_prod), longint'(e));
    chk(n == el, "R4 small latency", n, el);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] held;
    int n;
    start = 0; a = '0; b = '0;
    s_start = 0; s_a = '0; s_b = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(!busy && !done && prod == '0, "R7 reset state", longint'(prod), 0);
    chk(!s_busy && !s_done && s_prod == '0, "R7 reset state small", longint'(s_prod), 0);
    rst = 1'b0;
    @(negedge clk);

    // R5, R4, R1 corner operands
    run32(32'h1234_5678, 32'h0000_0000);
    run32(32'h1234_5678, 32'h0000_0001);
    run32(32'h89AB_CDEF, 32'hFFFF_FFFF);
    run32(32'h7FFF_FFFF, 32'h8000_0000);
    run32(32'h8000_0000, 32'h8000_0000);
    run32(32'hFFFF_FFFF, 32'h7FFF_FFFF);
    run32(32'h0000_0003, 32'h4000_0000);
    for (int k = 1; k < 16; k++) begin
      run32(32'hDEAD_BEEF, W'(longint'(1) << (2 * k - 1)));
      run32(32'hCAFE_F00D, W'(-(longint'(1) << (2 * k - 1))));
      run32(32'h0BAD_F00D, W'((longint'(1) << (2 * k - 1)) - 1));
    end
    for (int i = 0; i < 200; i++) run32($urandom, $urandom);
    for (int i = 0; i < 50; i++) run32($urandom, W'($urandom % 4096));

    // R6: start while busy is ignored
    @(negedge clk); start = 1'b1; a = 32'h0000_0007; b = 32'h8000_0000;
    @(negedge clk); start = 1'b0; a = '0; b = '0;
    n = 0;
    while (n < 40) begin
      @(negedge clk); n++;
      if (n == 3) begin start = 1'b1; a = 32'h1111_1111; b = 32'h0000_0002; end
      else start = 1'b0;
      if (done) break;
    end
    start = 1'b0;
    chk(n == 16, "R6 latency kept", n, 16);
    chk(prod == 32'h8000_0000, "R6 operands kept", longint'(prod), 32'h8000_0000);
    held = prod;
    // R3 done single cycle and product held; R6 no second run
    @(negedge clk);
    chk(!done, "R3 done one cycle", longint'(done), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!busy && !done && prod == held, "R6 no extra run / R3 hold", longint'(prod), longint'(held));
    end

    // R1 R4 exhaustive small-width sweep
    for (int x = 0; x < (1 << SW); x++)
      for (int y = 0; y < (1 << SW); y++)
        run6(SW'(x), SW'(y));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule